// File: doc/BRIEF.md
# Hybrid Column Counter for Single-Slope Conversion

This block is the digital back end of a row of single-slope column converters. The slow high-order part of each column's count sits in a small up/down counter inside that column. The fast low-order part comes from one shared counter whose value is broadcast to every column. A column does not count the low bits itself. It only copies the broadcast value into its own storage on the cycle its comparator reports that the ramp has crossed the pixel level. The comparators are modelled as one input bit per column, and a high bit means "crossed".

A start pulse runs a fixed sequence. First comes one clearing cycle. Next is a reset-sample phase, in which the high counters count down, and then a signal-sample phase, in which they count up. Each column's high difference is then merged with the two low latches into a correlated-double-sample code. That code is clamped at zero and at full scale. The codes are then scanned out one column per clock. The resolution is either 14 bits or 12 bits, chosen at start. In 12-bit mode the shared counter advances by four on each clock, so each phase is a quarter as long. A parameter chooses how a 12-bit result is presented: kept on the 14-bit scale with its two low bits at zero, or shifted right by two.

Top module: `hcc_top`

## Requirements
- R1: After reset, and whenever no readout is running, rd_valid, rd_last and rd_ovf are 0.
- R2: A start pulse sampled while idle is followed by one clearing cycle. After it come a reset phase and then a signal phase of PH cycles each, with PH = 16384 in 14-bit mode and 4096 in 12-bit mode. Readout starts on the cycle after the signal phase ends.
- R3: Let kR and kS be the 0-based cycle indices, counted within the reset phase and the signal phase, of the first cycle on which a column's cmp bit is high. The column's code is then STEP*(kS-kR), where STEP is 1 in 14-bit mode and 4 in 12-bit mode. This holds exactly for trips on either side of a wrap of the shared low counter.
- R4: A negative difference reads out as 0, and no code exceeds full scale (16383 in 14-bit mode, 16380 in 12-bit mode on the 14-bit scale).
- R5: A column whose cmp bit stays low for a whole phase is treated as tripping on the last cycle, index PH-1. Its rd_ovf is 1 when it is read out. For columns that tripped in both phases rd_ovf is 0.
- R6: In 12-bit mode with SHIFT12 = 0 the code is STEP*(kS-kR), and its two least-significant bits are 0. With SHIFT12 = 1 the code is kS-kR.
- R7: In 14-bit mode the full 14-bit range is reachable. A reset trip at index 1 and a signal trip at index 16383 give 16382.
- R8: Readout lasts exactly NCOL cycles. rd_col runs from 0 upward by one per clock, and rd_last is high only together with column NCOL-1.
- R9: A start pulse during the clearing cycle, either phase or readout has no effect. The running conversion's results and readout timing stay as if no pulse had occurred.
- R10: The mode input is sampled only when a start is accepted. Changing it during a conversion does not alter that conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a conversion when idle |
| mode14 | input | 1 | 1 selects 14-bit mode, 0 selects 12-bit mode; sampled at start |
| cmp | input | NCOL | Per-column comparator outputs, 1 once the ramp has crossed |
| rd_valid | output | 1 | A column result is presented |
| rd_col | output | $clog2(NCOL) | Index of the presented column |
| rd_data | output | LO_W+HI_W | Correlated-double-sample code |
| rd_last | output | 1 | The presented column is the last one |
| rd_ovf | output | 1 | The presented column never tripped in at least one phase |

## Verification
The cases hardest to reach from the ports are a trip that lands on the exact cycle the shared low counter wraps, and a column that never trips at all. Both need the comparator edge placed to a single cycle within a phase thousands of cycles long. The bench counts the phase cycles itself from the accepted start and raises each cmp bit as a level from a per-column trip index. It places trips at indices 31, 32 and 63 in 14-bit mode and at 7 and 8 in 12-bit mode, and it gives some columns an index beyond the phase so that they never trip. Ignored starts and a mode change are injected in the middle of a conversion and during readout. Two instances, one for each 12-bit presentation, are driven by the same stimulus.

// File: rtl/hcc_pkg.sv
package hcc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_RST,
    ST_SIG,
    ST_READ
  } hcc_state_e;

  // Merge high difference and two low latches into a code clamped to [0, full_scale].
  function automatic int hcc_cds(int hi_diff, int lo_sig, int lo_rst, int lo_w, int full_scale);
    int v;
    v = hi_diff * (1 << lo_w) + lo_sig - lo_rst;
    if (v < 0) v = 0;
    if (v > full_scale) v = full_scale;
    return v;
  endfunction

  // Full scale on the 14-bit scale for the selected mode.
  function automatic int hcc_full_scale(bit m14, int res_w, int drop);
    return m14 ? ((1 << res_w) - 1) : ((1 << res_w) - (1 << drop));
  endfunction

  // Present a code: reduced modes are optionally shifted down.
  function automatic int hcc_align(int v, bit m14, bit rshift, int drop);
    return (!m14 && rshift) ? (v >>> drop) : v;
  endfunction

endpackage

// File: rtl/hcc_lo_counter.sv
module hcc_lo_counter #(
  parameter int LO_W = 5,
  parameter int DROP = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            run,
  input  logic            m14,
  output logic [LO_W-1:0] lo,
  output logic            wrap
);
  localparam logic [LO_W:0] STEP_FULL = (LO_W+1)'(1);
  localparam logic [LO_W:0] STEP_RED  = (LO_W+1)'(1 << DROP);

  logic [LO_W:0] step;
  logic [LO_W:0] nxt;

  always_comb begin
    step = m14 ? STEP_FULL : STEP_RED;
    nxt  = {1'b0, lo} + step;
    wrap = run && nxt[LO_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lo <= '0;
    else if (clr) lo <= '0;
    else if (run) lo <= nxt[LO_W-1:0];
  end
endmodule

// File: rtl/hcc_seq.sv
module hcc_seq
  import hcc_pkg::*;
#(
  parameter int NCOL  = 248,
  parameter int RES_W = 14,
  parameter int DROP  = 2,
  localparam int CW   = (NCOL > 1) ? $clog2(NCOL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode14,
  output logic          m14_q,
  output logic          clr_p,
  output logic          rst_ph,
  output logic          sig_ph,
  output logic          ph_last,
  output logic          rd_en,
  output logic [CW-1:0] rd_idx,
  output logic          rd_last,
  output logic          busy
);
  localparam logic [RES_W-1:0] END_FULL = '1;
  localparam logic [RES_W-1:0] END_RED  = RES_W'((1 << (RES_W - DROP)) - 1);
  localparam logic [CW-1:0]    LAST_COL = CW'(NCOL - 1);

  hcc_state_e       state;
  logic [RES_W-1:0] pcnt;

  always_comb begin
    clr_p   = (state == ST_CLEAR);
    rst_ph  = (state == ST_RST);
    sig_ph  = (state == ST_SIG);
    rd_en   = (state == ST_READ);
    busy    = (state != ST_IDLE);
    ph_last = (rst_ph || sig_ph) && (pcnt == (m14_q ? END_FULL : END_RED));
    rd_last = rd_en && (rd_idx == LAST_COL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      m14_q  <= 1'b1;
      pcnt   <= '0;
      rd_idx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_CLEAR;
          m14_q <= mode14;
        end
        ST_CLEAR: begin
          state <= ST_RST;
          pcnt  <= '0;
        end
        ST_RST: begin
          if (ph_last) begin
            state <= ST_SIG;
            pcnt  <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        ST_SIG: begin
          if (ph_last) begin
            state  <= ST_READ;
            rd_idx <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        ST_READ: begin
          if (rd_last) state <= ST_IDLE;
          else         rd_idx <= rd_idx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hcc_col.sv
module hcc_col #(
  parameter int LO_W = 5,
  parameter int HI_W = 9,
  localparam int HC_W = HI_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   rst_ph,
  input  logic                   sig_ph,
  input  logic                   ph_last,
  input  logic                   wrap,
  input  logic [LO_W-1:0]        lo,
  input  logic                   cmp,
  output logic signed [HC_W-1:0] hi,
  output logic [LO_W-1:0]        lo_r,
  output logic [LO_W-1:0]        lo_s,
  output logic                   ovf,
  output logic                   tripped
);
  logic in_ph;
  logic fire;
  logic step_hi;

  always_comb begin
    in_ph   = rst_ph || sig_ph;
    fire    = in_ph && !tripped && (cmp || ph_last);
    step_hi = in_ph && !tripped && !fire && wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi      <= '0;
      lo_r    <= '0;
      lo_s    <= '0;
      ovf     <= 1'b0;
      tripped <= 1'b0;
    end else if (clr) begin
      hi      <= '0;
      lo_r    <= '0;
      lo_s    <= '0;
      ovf     <= 1'b0;
      tripped <= 1'b0;
    end else begin
      if (fire) begin
        if (rst_ph) lo_r <= lo;
        else        lo_s <= lo;
        tripped <= 1'b1;
        if (!cmp) ovf <= 1'b1;
      end
      if (step_hi) hi <= rst_ph ? hi - 1'b1 : hi + 1'b1;
      if (rst_ph && ph_last) tripped <= 1'b0;
    end
  end
endmodule

// File: rtl/hcc_top.sv
module hcc_top
  import hcc_pkg::*;
#(
  parameter int NCOL    = 248,
  parameter int LO_W    = 5,
  parameter int HI_W    = 9,
  parameter bit SHIFT12 = 1'b0,
  localparam int RES_W  = LO_W + HI_W,
  localparam int DROP   = 2,
  localparam int HC_W   = HI_W + 1,
  localparam int CW     = (NCOL > 1) ? $clog2(NCOL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode14,
  input  logic [NCOL-1:0]  cmp,
  output logic             rd_valid,
  output logic [CW-1:0]    rd_col,
  output logic [RES_W-1:0] rd_data,
  output logic             rd_last,
  output logic             rd_ovf
);
  logic          m14_q, clr_p, rst_ph, sig_ph, ph_last, rd_en, rd_end, busy;
  logic [CW-1:0] rd_idx;
  logic [LO_W-1:0] lo;
  logic          wrap;
  logic          conv_run;

  logic signed [HC_W-1:0] hi_a   [NCOL];
  logic [LO_W-1:0]        lor_a  [NCOL];
  logic [LO_W-1:0]        los_a  [NCOL];
  logic                   ovf_a  [NCOL];
  logic                   trip_a [NCOL];

  assign conv_run = rst_ph || sig_ph;

  hcc_seq #(.NCOL(NCOL), .RES_W(RES_W), .DROP(DROP)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode14(mode14),
    .m14_q(m14_q), .clr_p(clr_p), .rst_ph(rst_ph), .sig_ph(sig_ph),
    .ph_last(ph_last), .rd_en(rd_en), .rd_idx(rd_idx), .rd_last(rd_end),
    .busy(busy)
  );

  hcc_lo_counter #(.LO_W(LO_W), .DROP(DROP)) u_lo (
    .clk(clk), .rst_n(rst_n), .clr(clr_p), .run(conv_run), .m14(m14_q),
    .lo(lo), .wrap(wrap)
  );

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    hcc_col #(.LO_W(LO_W), .HI_W(HI_W)) u_col (
      .clk(clk), .rst_n(rst_n), .clr(clr_p), .rst_ph(rst_ph), .sig_ph(sig_ph),
      .ph_last(ph_last), .wrap(wrap), .lo(lo), .cmp(cmp[c]),
      .hi(hi_a[c]), .lo_r(lor_a[c]), .lo_s(los_a[c]), .ovf(ovf_a[c]),
      .tripped(trip_a[c])
    );
  end

  // Single shared merge stage behind the column select.
  logic signed [HC_W-1:0] sel_hi;
  logic [LO_W-1:0]        sel_lr, sel_ls;
  logic                   sel_ovf;
  int                     code;

  // Named internal events for the checker.
  logic signed [HC_W-1:0] hi0;
  logic                   trip0;
  assign hi0   = hi_a[0];
  assign trip0 = trip_a[0];

  always_comb begin
    sel_hi  = hi_a[rd_idx];
    sel_lr  = lor_a[rd_idx];
    sel_ls  = los_a[rd_idx];
    sel_ovf = ovf_a[rd_idx];
    code = hcc_align(hcc_cds(int'(sel_hi), int'(sel_ls), int'(sel_lr), LO_W,
                             hcc_full_scale(m14_q, RES_W, DROP)),
                     m14_q, SHIFT12, DROP);
    rd_valid = rd_en;
    rd_last  = rd_end;
    rd_col   = rd_en ? rd_idx : '0;
    rd_data  = rd_en ? code[RES_W-1:0] : '0;
    rd_ovf   = rd_en && sel_ovf;
  end
endmodule

// File: rtl/hcc_checker.sv
module hcc_checker #(
  parameter int NCOL    = 248,
  parameter int LO_W    = 5,
  parameter int RES_W   = 14,
  parameter int DROP    = 2,
  parameter int HC_W    = 10,
  parameter int CW      = 8,
  parameter bit SHIFT12 = 1'b0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   busy,
  input logic                   clr_p,
  input logic                   conv_run,
  input logic                   m14_q,
  input logic [LO_W-1:0]        lo,
  input logic signed [HC_W-1:0] hi0,
  input logic                   trip0,
  input logic                   rd_valid,
  input logic [CW-1:0]          rd_col,
  input logic [RES_W-1:0]       rd_data,
  input logic                   rd_last,
  input logic                   rd_ovf
);
  localparam int FS_FULL = (1 << RES_W) - 1;
  localparam int FS_RED  = SHIFT12 ? (((1 << RES_W) - (1 << DROP)) >> DROP)
                                   : ((1 << RES_W) - (1 << DROP));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_valid && !rd_last && !rd_ovf));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !clr_p);

  p_lo_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(conv_run) |-> (lo == LO_W'(int'($past(lo)) + (m14_q ? 1 : (1 << DROP)))));

  p_hold_after_trip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(trip0) && trip0) |-> $stable(hi0));

  p_col_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_last) |=> (rd_valid && (rd_col == CW'(int'($past(rd_col)) + 1))));

  p_last_col_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> (rd_valid && (rd_col == CW'(NCOL - 1))));

  p_last_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |=> !rd_valid);

  p_full_scale_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (int'(rd_data) <= (m14_q ? FS_FULL : FS_RED)));

  p_low_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !m14_q && !SHIFT12) |-> (rd_data[DROP-1:0] == '0));
endmodule

bind hcc_top hcc_checker #(
  .NCOL(NCOL), .LO_W(LO_W), .RES_W(RES_W), .DROP(DROP), .HC_W(HC_W), .CW(CW),
  .SHIFT12(SHIFT12)
) u_hcc_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .clr_p(clr_p),
  .conv_run(conv_run), .m14_q(m14_q), .lo(lo), .hi0(hi0), .trip0(trip0),
  .rd_valid(rd_valid), .rd_col(rd_col), .rd_data(rd_data), .rd_last(rd_last),
  .rd_ovf(rd_ovf)
);

// File: tb/test_hcc_top.sv
module test_hcc_top;
  localparam int NCOL = 8;
  localparam int CW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode14 = 1'b1;
  logic [NCOL-1:0] cmp = '0;

  logic          v0, l0, o0, v1, l1, o1;
  logic [CW-1:0] c0, c1;
  logic [13:0]   d0, d1;

  int n_cmp = 0;
  int n_bad = 0;
  bit in_read = 1'b0;
  bit done = 1'b0;
  int tr_r [NCOL];
  int tr_s [NCOL];

  always #2 clk = ~clk;

  hcc_top #(.NCOL(NCOL), .SHIFT12(1'b0)) i_hcc_top (
    .clk(clk), .rst_n(rst_n), .start(start), .mode14(mode14), .cmp(cmp),
    .rd_valid(v0), .rd_col(c0), .rd_data(d0), .rd_last(l0), .rd_ovf(o0));

  hcc_top #(.NCOL(NCOL), .SHIFT12(1'b1)) i_hcc_top_rs (
    .clk(clk), .rst_n(rst_n), .start(start), .mode14(mode14), .cmp(cmp),
    .rd_valid(v1), .rd_col(c1), .rd_data(d1), .rd_last(l1), .rd_ovf(o1));

  task automatic chk(int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Reference: code from the trip indices (R3, R4, R5, R6, R7).
  function automatic int ref_code(int tr, int ts, bit m14, bit rs);
    int ph, st, kr, ks, d;
    ph = m14 ? 16384 : 4096;
    st = m14 ? 1 : 4;
    kr = (tr >= ph) ? ph - 1 : tr;
    ks = (ts >= ph) ? ph - 1 : ts;
    d  = st * (ks - kr);
    if (d < 0) d = 0;
    if (rs && !m14) d = d / 4;
    return d;
  endfunction

  function automatic bit ref_ovf(int tr, int ts, bit m14);
    int ph;
    ph = m14 ? 16384 : 4096;
    return (tr >= ph) || (ts >= ph);
  endfunction

  // Every-clock comparison outside readout windows (R1).
  always @(negedge clk) begin
    if (rst_n && !in_read && !done) begin
      chk(int'({v0, l0, o0, v1, l1, o1}), 0, "R1 outputs quiet outside readout");
    end
  end

  // One full conversion with optional ignored starts (R9) and mode flip (R10).
  task automatic run_conv(bit m14, bit poke, string tag);
    int ph;
    ph = m14 ? 16384 : 4096;
    @(negedge clk);
    mode14 = m14;
    start  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = poke;
    @(posedge clk);
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < ph; k++) begin
        @(negedge clk);
        for (int c = 0; c < NCOL; c++)
          cmp[c] = (k >= ((p == 0) ? tr_r[c] : tr_s[c]));
        start = poke && (k == 50);
        if (poke && p == 0 && k == 10) mode14 = !m14;
        @(posedge clk);
      end
    end
    in_read = 1'b1;
    for (int c = 0; c < NCOL; c++) begin
      @(negedge clk);
      start = poke && (c == 1);
      chk(int'(v0), 1, {tag, " R8 valid"});
      chk(int'(c0), c, {tag, " R8 column order"});
      chk(int'(l0), (c == NCOL - 1) ? 1 : 0, {tag, " R8 last marker"});
      chk(int'(d0), ref_code(tr_r[c], tr_s[c], m14, 1'b0), {tag, " R3 code"});
      chk(int'(d1), ref_code(tr_r[c], tr_s[c], m14, 1'b1), {tag, " R6 shifted code"});
      chk(int'(o0), int'(ref_ovf(tr_r[c], tr_s[c], m14)), {tag, " R5 overflow flag"});
      chk(int'({v1, c1, l1, o1}), int'({v0, c0, l0, o0}), {tag, " R8 twin readout"});
      @(posedge clk);
    end
    @(negedge clk);
    start = 1'b0;
    in_read = 1'b0;
    cmp = '0;
    mode14 = m14;
    chk(int'(v0), 0, {tag, " R8 readout length"});
  endtask

  task automatic set_col(int c, int r, int s);
    tr_r[c] = r;
    tr_s[c] = s;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(int'({v0, l0, o0}), 0, "R1 reset state");
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // 14-bit: wrap boundaries, clamp, overflow, full range (R2, R3, R4, R5, R7).
    set_col(0, 0, 0);
    set_col(1, 100, 5000);
    set_col(2, 31, 32);
    set_col(3, 32, 63);
    set_col(4, 5000, 100);
    set_col(5, 0, 99999);
    set_col(6, 99999, 99999);
    set_col(7, 1, 16383);
    run_conv(1'b1, 1'b0, "m14a R7");

    // 12-bit: wrap at 8 steps, both presentations (R2, R3, R4, R5, R6).
    set_col(0, 7, 8);
    set_col(1, 8, 15);
    set_col(2, 0, 4095);
    set_col(3, 99999, 10);
    set_col(4, 200, 100);
    set_col(5, 0, 99999);
    set_col(6, 1000, 3000);
    set_col(7, 3, 3);
    run_conv(1'b0, 1'b0, "m12a R6");

    // 12-bit with ignored starts and a mode change mid-run (R9, R10).
    set_col(0, 15, 16);
    set_col(1, 1, 4094);
    set_col(2, 2047, 2048);
    set_col(3, 4000, 4095);
    set_col(4, 99999, 0);
    set_col(5, 64, 63);
    set_col(6, 5, 4000);
    set_col(7, 9, 99999);
    run_conv(1'b0, 1'b1, "m12b R9 R10");

    // 14-bit with ignored starts (R9) and other wrap points (R3).
    set_col(0, 63, 64);
    set_col(1, 0, 31);
    set_col(2, 16383, 16383);
    set_col(3, 16382, 99999);
    set_col(4, 480, 8191);
    set_col(5, 8192, 8191);
    set_col(6, 1, 2);
    set_col(7, 12345, 15000);
    run_conv(1'b1, 1'b1, "m14b R9");

    repeat (4) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule